// File: doc/BRIEF.md
# Dynamic Bimodal Insertion Policy Controller

This block sits beside the tag array of a set-associative cache that keeps a full recency stack per set. For each access it receives the set index, whether the access hit, and (on a hit) the way that hit. It then returns the way to fill or promote, whether that line now sits at the most-recently-used end of the stack, which insertion policy was applied, and the updated recency ranks of the whole set. The recency ranks are held inside the block. Tags and data are held elsewhere.

On a miss, a line can enter in one of two places. It can enter at the most-recently-used end, which is classic LRU behaviour. It can instead stay in the least-recently-used slot it replaced. Bimodal insertion uses the second choice most of the time and the first only on a pseudo-random one-in-32 draw. This protects the cache against working sets that thrash it.

In dynamic mode, two small groups of sets always use one fixed policy each. A saturating selector counts which group misses more, and every other set follows whichever policy is currently winning. Three fixed modes force one policy on every set.

Top module: `dip_insert_ctrl`

## Requirements
- R1: After reset, in every set, way i holds recency rank i. Rank 0 is most-recently-used and rank WAYS-1 is least-recently-used. rsp_ranks packs the rank of way i into bits [3i+2:3i] (3 bits per way, 8 ways by default). The ranks of a set always form a permutation of 0..WAYS-1.
- R2: On a hit to way w, the line moves to rank 0 in every mode and under every policy.
  - Lines that had a lower rank than w move down by one; all other lines keep their rank.
  - rsp_victim is w and rsp_ins_mru is 1.
  - A hit changes neither the selector nor the pseudo-random generator.
- R3: On a miss under MRU insertion (rsp_policy 0), the victim is the way holding rank WAYS-1. The victim goes to rank 0, every other way moves down by one, and rsp_ins_mru is 1.
- R4: On a miss under LRU-position insertion (rsp_policy 1), the victim is the way holding rank WAYS-1. All ranks of the set stay unchanged, and rsp_ins_mru is 0.
- R5: Bimodal insertion (rsp_policy 2) behaves like R3 when the five low bits of a 16-bit generator are all zero, and like R4 otherwise.
  - The generator's value before the current miss is used.
  - The generator resets to 16'h0001.
  - On every miss, in any set and any mode, it steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: In dynamic mode (cfg_mode 0), sets with index mod 4 equal to 0 always use MRU insertion (rsp_policy 0). Sets with index mod 4 equal to 1 always use bimodal insertion (rsp_policy 2). With the default 128 sets and 32 sets per group, this gives 32 sets in each group.
- R7: A 10-bit selector resets to 511 and is updated in every mode.
  - A miss in an index-mod-4-equal-0 set increments it, saturating at 1023.
  - A miss in an index-mod-4-equal-1 set decrements it, saturating at 0.
  - Misses in other sets leave it unchanged.
- R8: In dynamic mode, the other sets (index mod 4 of 2 or 3) use bimodal insertion when the selector's top bit is 1, and MRU insertion otherwise.
- R9: cfg_mode 1 forces MRU insertion in every set, cfg_mode 2 forces LRU-position insertion, and cfg_mode 3 forces bimodal insertion. In these modes rsp_policy equals cfg_mode minus 1.
- R10: A request accepted at a clock edge produces its response, with rsp_valid high, right after that edge. A cycle without a request gives rsp_valid low.
- R11: On a miss, req_way is ignored: the victim is chosen only from the recency ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 dynamic, 1 MRU insertion, 2 LRU-position insertion, 3 bimodal |
| req_valid | input | 1 | Access present this cycle |
| req_set | input | 7 | Set index |
| req_hit | input | 1 | 1 when the access hit |
| req_way | input | 3 | Way that hit (ignored on a miss) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit flag of the answered access |
| rsp_victim | output | 3 | Way filled on a miss, or promoted on a hit |
| rsp_ins_mru | output | 1 | 1 when that way now holds rank 0 |
| rsp_policy | output | 2 | 0 MRU insertion, 1 LRU-position, 2 bimodal |
| rsp_ranks | output | 24 | Updated ranks of the set, 3 bits per way |

## Verification
The selector is driven into both saturation limits and then stepped across its top-bit boundary from each side. Sets outside the dueling groups are probed with hits, which change neither counter nor generator, so they reveal which policy the sets are following. A counter that wraps instead of saturating would flip the followers to the wrong policy at once. An off-by-one threshold would switch them one miss early or late.

Long runs of bimodal misses follow the generator step for step. A design that advanced it on hits, or that drew from the post-step value, would insert at MRU on the wrong misses. Repeated misses under LRU-position insertion must keep refilling the same way. A design that took the victim from req_way, or that promoted on every miss, would report a different victim or changed ranks.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int RNG_W = 16;
    localparam logic [RNG_W-1:0] RNG_SEED = 16'h0001;

    typedef enum logic [1:0] {
        MODE_DUEL    = 2'd0,
        MODE_MRU     = 2'd1,
        MODE_LRUPOS  = 2'd2,
        MODE_BIMODAL = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        POL_MRU     = 2'd0,
        POL_LRUPOS  = 2'd1,
        POL_BIMODAL = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        KIND_FOLLOW   = 2'd0,
        KIND_LEAD_MRU = 2'd1,
        KIND_LEAD_BIM = 2'd2
    } set_kind_e;

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic set_kind_e kind_of(input int unsigned idx, input int unsigned stride);
        int unsigned m;
        m = idx % stride;
        if (m == 0) return KIND_LEAD_MRU;
        if (m == 1) return KIND_LEAD_BIM;
        return KIND_FOLLOW;
    endfunction

    function automatic pol_e pick_policy(input mode_e mode, input set_kind_e kind,
                                         input logic prefer_bim);
        pol_e p;
        unique case (mode)
            MODE_MRU:     p = POL_MRU;
            MODE_LRUPOS:  p = POL_LRUPOS;
            MODE_BIMODAL: p = POL_BIMODAL;
            default: begin
                unique case (kind)
                    KIND_LEAD_MRU: p = POL_MRU;
                    KIND_LEAD_BIM: p = POL_BIMODAL;
                    default:       p = prefer_bim ? POL_BIMODAL : POL_MRU;
                endcase
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dip_rng.sv
module dip_rng
    import dip_pkg::*;
#(
    parameter int PROB_BITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic coin
);
    logic [RNG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RNG_SEED;
        end else if (adv) begin
            state_q <= rng_step(state_q);
        end
    end

    assign coin = (state_q[PROB_BITS-1:0] == '0);
endmodule

// File: rtl/dip_selector.sv
module dip_selector #(
    parameter int SEL_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic prefer_bim
);
    localparam logic [SEL_W-1:0] SEL_MAX = {SEL_W{1'b1}};
    localparam logic [SEL_W-1:0] SEL_MID = {1'b0, {(SEL_W-1){1'b1}}};

    logic [SEL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= SEL_MID;
        end else if (inc && !dec && cnt_q != SEL_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign prefer_bim = cnt_q[SEL_W-1];
endmodule

// File: rtl/dip_recency.sv
module dip_recency #(
    parameter int SETS = 128,
    parameter int WAYS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   upd_en,
    input  logic [$clog2(SETS)-1:0]                set_idx,
    input  logic                                   hit,
    input  logic [$clog2(WAYS)-1:0]                hit_way,
    input  logic                                   ins_mru,
    output logic [$clog2(WAYS)-1:0]                target,
    output logic [WAYS-1:0][$clog2(WAYS)-1:0]      next_row
);
    localparam int WW = $clog2(WAYS);
    localparam logic [WW-1:0] LRU_RANK = WW'(WAYS - 1);

    typedef logic [WAYS-1:0][WW-1:0] row_t;

    row_t            rank_q [SETS];
    row_t            cur;
    logic [WW-1:0]   lru_way;
    logic [WW-1:0]   tgt_rank;
    logic            promote;

    always_comb begin
        cur     = rank_q[set_idx];
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cur[w] == LRU_RANK) lru_way = WW'(w);
        end
        target   = hit ? hit_way : lru_way;
        tgt_rank = cur[target];
        promote  = hit | ins_mru;
        next_row = cur;
        if (promote) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WW'(w) == target) begin
                    next_row[w] = '0;
                end else if (cur[w] < tgt_rank) begin
                    next_row[w] = cur[w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WW'(w);
                end
            end
        end else if (upd_en) begin
            rank_q[set_idx] <= next_row;
        end
    end
endmodule

// File: rtl/dip_insert_ctrl.sv
module dip_insert_ctrl
    import dip_pkg::*;
#(
    parameter int SETS      = 128,
    parameter int WAYS      = 8,
    parameter int LEADERS   = 32,
    parameter int SEL_W     = 10,
    parameter int PROB_BITS = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        cfg_mode,
    input  logic                              req_valid,
    input  logic [$clog2(SETS)-1:0]           req_set,
    input  logic                              req_hit,
    input  logic [$clog2(WAYS)-1:0]           req_way,
    output logic                              rsp_valid,
    output logic                              rsp_hit,
    output logic [$clog2(WAYS)-1:0]           rsp_victim,
    output logic                              rsp_ins_mru,
    output logic [1:0]                        rsp_policy,
    output logic [WAYS*$clog2(WAYS)-1:0]      rsp_ranks
);
    localparam int WW     = $clog2(WAYS);
    localparam int STRIDE = SETS / LEADERS;

    set_kind_e                 kind;
    pol_e                      pol;
    logic                      prefer_bim;
    logic                      coin;
    logic                      miss;
    logic                      ins_mru;
    logic [WW-1:0]             target;
    logic [WAYS-1:0][WW-1:0]   next_row;

    always_comb begin
        kind    = kind_of(int'(req_set), STRIDE);
        pol     = pick_policy(mode_e'(cfg_mode), kind, prefer_bim);
        miss    = req_valid & ~req_hit;
        ins_mru = req_hit | (pol == POL_MRU) | ((pol == POL_BIMODAL) & coin);
    end

    dip_rng #(.PROB_BITS(PROB_BITS)) u_rng (
        .clk  (clk),
        .rst  (rst),
        .adv  (miss),
        .coin (coin)
    );

    dip_selector #(.SEL_W(SEL_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .inc        (miss && kind == KIND_LEAD_MRU),
        .dec        (miss && kind == KIND_LEAD_BIM),
        .prefer_bim (prefer_bim)
    );

    dip_recency #(.SETS(SETS), .WAYS(WAYS)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (req_valid),
        .set_idx  (req_set),
        .hit      (req_hit),
        .hit_way  (req_way),
        .ins_mru  (ins_mru),
        .target   (target),
        .next_row (next_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_victim  <= '0;
            rsp_ins_mru <= 1'b0;
            rsp_policy  <= '0;
            rsp_ranks   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit     <= req_hit;
                rsp_victim  <= target;
                rsp_ins_mru <= ins_mru;
                rsp_policy  <= pol;
                rsp_ranks   <= next_row;
            end
        end
    end
endmodule

// File: rtl/dip_insert_ctrl_chk.sv
module dip_insert_ctrl_chk #(
    parameter int SETS    = 128,
    parameter int WAYS    = 8,
    parameter int LEADERS = 32
) (
    input logic                              clk,
    input logic                              rst,
    input logic [1:0]                        cfg_mode,
    input logic                              req_valid,
    input logic [$clog2(SETS)-1:0]           req_set,
    input logic                              req_hit,
    input logic [$clog2(WAYS)-1:0]           req_way,
    input logic                              rsp_valid,
    input logic                              rsp_hit,
    input logic [$clog2(WAYS)-1:0]           rsp_victim,
    input logic                              rsp_ins_mru,
    input logic [1:0]                        rsp_policy,
    input logic [WAYS*$clog2(WAYS)-1:0]      rsp_ranks
);
    localparam int WW = $clog2(WAYS);
    localparam int SB = $clog2(SETS / LEADERS);

    logic [WAYS-1:0] seen;
    logic [WW-1:0]   vic_rank;
    logic            lead_mru;
    logic            lead_bim;

    always_comb begin
        seen     = '0;
        vic_rank = '0;
        for (int w = 0; w < WAYS; w++) begin
            seen[rsp_ranks[w*WW +: WW]] = 1'b1;
            if (WW'(w) == rsp_victim) vic_rank = rsp_ranks[w*WW +: WW];
        end
        lead_mru = (req_set[SB-1:0] == SB'(0));
        lead_bim = (req_set[SB-1:0] == SB'(1));
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R1
    ranks_perm_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (seen == {WAYS{1'b1}}));

    // R2
    hit_to_mru_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_ins_mru && vic_rank == '0);

    // R2
    hit_way_echo_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_hit |=> rsp_victim == $past(req_way));

    // R3
    mru_miss_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit && rsp_policy == 2'd0 |-> rsp_ins_mru && vic_rank == '0);

    // R4
    lrupos_stay_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit && !rsp_ins_mru |-> vic_rank == WW'(WAYS - 1));

    // R4
    lrupos_no_mru_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit && rsp_policy == 2'd1 |-> !rsp_ins_mru);

    // R6
    lead_mru_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_mode == 2'd0 && lead_mru |=> rsp_policy == 2'd0);

    // R6
    lead_bim_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_mode == 2'd0 && lead_bim |=> rsp_policy == 2'd2);

    // R9
    fixed_mode_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_mode != 2'd0 |=> rsp_policy == $past(cfg_mode) - 2'd1);
endmodule

bind dip_insert_ctrl dip_insert_ctrl_chk #(
    .SETS(SETS), .WAYS(WAYS), .LEADERS(LEADERS)
) u_chk (.*);

// File: tb/sim_dip_insert_ctrl.sv
module sim_dip_insert_ctrl;
    localparam int SETS   = 128;
    localparam int WAYS   = 8;
    localparam int WW     = 3;
    localparam int STRIDE = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           cfg_mode = 2'd0;
    logic                 req_valid = 1'b0;
    logic [6:0]           req_set = '0;
    logic                 req_hit = 1'b0;
    logic [2:0]           req_way = '0;
    logic                 rsp_valid;
    logic                 rsp_hit;
    logic [2:0]           rsp_victim;
    logic                 rsp_ins_mru;
    logic [1:0]           rsp_policy;
    logic [23:0]          rsp_ranks;

    int n_chk = 0;
    int n_err = 0;

    int          m_rank [SETS][WAYS];
    logic [15:0] m_rng;
    int          m_sel;

    always #4 clk = ~clk;

    dip_insert_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .req_valid(req_valid),
        .req_set(req_set), .req_hit(req_hit), .req_way(req_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_victim(rsp_victim),
        .rsp_ins_mru(rsp_ins_mru), .rsp_policy(rsp_policy), .rsp_ranks(rsp_ranks)
    );

    task automatic check_eq(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] model_row(int s);
        logic [23:0] r = '0;
        for (int i = 0; i < WAYS; i++) r[i*WW +: WW] = 3'(m_rank[s][i]);
        return r;
    endfunction

    // One access, driven at a negedge and checked at the next negedge.
    task automatic access(int s, bit h, int w, string tag);
        int kind, pol, tgt, r;
        bit coin, exp_mru;
        kind = (s % STRIDE == 0) ? 1 : (s % STRIDE == 1) ? 2 : 0;
        case (cfg_mode)
            2'd0: pol = (kind == 1) ? 0 : (kind == 2) ? 2 : (m_sel >= 512 ? 2 : 0);
            2'd1: pol = 0;
            2'd2: pol = 1;
            default: pol = 2;
        endcase
        coin    = (m_rng[4:0] == 5'd0);
        exp_mru = h || pol == 0 || (pol == 2 && coin);
        tgt = w;
        if (!h) for (int i = 0; i < WAYS; i++) if (m_rank[s][i] == WAYS - 1) tgt = i;
        if (exp_mru) begin
            r = m_rank[s][tgt];
            for (int i = 0; i < WAYS; i++) begin
                if (i == tgt) m_rank[s][i] = 0;
                else if (m_rank[s][i] < r) m_rank[s][i]++;
            end
        end
        if (!h) begin
            m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
            if (kind == 1 && m_sel < 1023) m_sel++;
            if (kind == 2 && m_sel > 0) m_sel--;
        end
        req_valid = 1'b1;
        req_set   = 7'(s);
        req_hit   = h;
        req_way   = 3'(w);
        @(negedge clk);
        req_valid = 1'b0;
        check_eq(tag, "rsp_valid", rsp_valid, 1);
        check_eq(tag, "victim", rsp_victim, tgt);
        check_eq(tag, "ins_mru", rsp_ins_mru, exp_mru);
        check_eq(tag, "policy", rsp_policy, pol);
        check_eq(tag, "ranks", rsp_ranks, model_row(s));
    endtask

    task automatic t_reset();
        logic [23:0] ident = '0;
        for (int i = 0; i < WAYS; i++) ident[i*WW +: WW] = 3'(i);
        check_eq("R10", "rsp_valid after reset", rsp_valid, 0);
        cfg_mode = 2'd0;
        access(2, 1'b1, 0, "R1");
        check_eq("R1", "identity ranks", rsp_ranks, ident);
        access(77, 1'b1, 0, "R1");
        check_eq("R1", "identity ranks set 77", rsp_ranks, ident);
    endtask

    task automatic t_hit();
        cfg_mode = 2'd2;
        access(6, 1'b1, 5, "R2");
        check_eq("R2", "hit promotes under lru-position mode", rsp_ins_mru, 1);
        access(6, 1'b1, 2, "R2");
        access(6, 1'b1, 7, "R2");
        access(6, 1'b1, 5, "R2");
    endtask

    task automatic t_mru_miss();
        cfg_mode = 2'd1;
        access(9, 1'b0, 0, "R3");
        check_eq("R3", "first victim", rsp_victim, 7);
        access(9, 1'b0, 0, "R3");
        check_eq("R3", "second victim", rsp_victim, 6);
    endtask

    task automatic t_lrupos();
        cfg_mode = 2'd2;
        access(10, 1'b0, 1, "R4");
        check_eq("R4", "victim", rsp_victim, 7);
        access(10, 1'b0, 4, "R4");
        check_eq("R4", "same victim again", rsp_victim, 7);
    endtask

    task automatic t_bimodal();
        cfg_mode = 2'd3;
        for (int i = 0; i < 200; i++) begin
            access(11, 1'b0, 0, "R5");
            if (i % 3 == 0) access(12, 1'b1, i % WAYS, "R5");
        end
    endtask

    task automatic t_way_ignored();
        cfg_mode = 2'd0;
        access(14, 1'b0, 3, "R11");
        check_eq("R11", "victim not req_way", rsp_victim, 7);
        access(18, 1'b0, 0, "R11");
        check_eq("R11", "victim not req_way", rsp_victim, 7);
    endtask

    task automatic t_leaders();
        cfg_mode = 2'd0;
        access(0, 1'b1, 3, "R6");
        check_eq("R6", "mru leader policy", rsp_policy, 0);
        access(33, 1'b1, 3, "R6");
        check_eq("R6", "bimodal leader policy", rsp_policy, 2);
    endtask

    task automatic t_fixed();
        cfg_mode = 2'd1;
        access(1, 1'b1, 0, "R9");
        check_eq("R9", "mode 1 on bimodal leader", rsp_policy, 0);
        cfg_mode = 2'd3;
        access(0, 1'b1, 0, "R9");
        check_eq("R9", "mode 3 on mru leader", rsp_policy, 2);
        cfg_mode = 2'd2;
        access(2, 1'b1, 0, "R9");
        check_eq("R9", "mode 2 on follower", rsp_policy, 1);
    endtask

    task automatic t_duel();
        cfg_mode = 2'd0;
        for (int i = 0; i < 1100; i++) access((i % 32) * 4, 1'b0, 0, "R7");
        access(3, 1'b0, 0, "R7");
        access(2, 1'b1, 0, "R8");
        check_eq("R8", "saturated high follows bimodal", rsp_policy, 2);
        for (int i = 0; i < 511; i++) access((i % 32) * 4 + 1, 1'b0, 0, "R7");
        access(6, 1'b1, 1, "R8");
        check_eq("R8", "selector 512 still bimodal", rsp_policy, 2);
        access(5, 1'b0, 0, "R7");
        access(6, 1'b1, 1, "R8");
        check_eq("R8", "selector 511 back to mru", rsp_policy, 0);
        for (int i = 0; i < 1100; i++) access((i % 32) * 4 + 1, 1'b0, 0, "R7");
        for (int i = 0; i < 511; i++) access((i % 32) * 4, 1'b0, 0, "R7");
        access(7, 1'b1, 2, "R8");
        check_eq("R8", "from floor 511 is mru", rsp_policy, 0);
        access(4, 1'b0, 0, "R7");
        access(7, 1'b1, 2, "R8");
        check_eq("R8", "from floor 512 is bimodal", rsp_policy, 2);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check_eq("R10", "no request gives no response", rsp_valid, 0);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_rank[s][w] = w;
        m_rng = 16'h0001;
        m_sel = 511;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hit();
        t_mru_miss();
        t_lrupos();
        t_bimodal();
        t_way_ignored();
        t_leaders();
        t_fixed();
        t_duel();
        t_idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule